// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is a read-only cache that sits between a requester and a slower line-oriented memory. Its main store is a direct-mapped array: each line has a valid bit, a tag and a full line of data. A small fully associative buffer sits behind it. This buffer keeps lines that have recently been pushed out of the main array, so that two addresses fighting over the same index do not keep sending refills to memory.

A request is a byte address. The block accepts it through a valid/ready handshake and answers with one data word and flags that give the source of the data. The block first checks the main array. On a miss it searches every victim slot at the same time. The address match in the victim buffer uses the whole line address, so a slot can hold a line from any index. If a victim slot holds the line, the two lines swap places without any memory traffic. If neither structure holds the line, the block requests a full line from memory and installs it in the main array. A valid line that the refill pushes out enters the victim buffer and takes the place of its oldest entry.

Top module: `vc_cache`

## Requirements
- R1: Reset invalidates every line of the main array and every victim slot. After reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0, and the first access to any address goes to memory.
- R2: A byte address splits into three fields. The lowest log2(LINE_BYTES) bits are the byte offset, the next log2(NUM_LINES) bits are the index, and the remaining upper bits are the tag. The returned word is word number `addr[log2(LINE_BYTES)-1 : log2(WORD_W/8)]` of the line, and word w sits at line bits `[w*WORD_W +: WORD_W]`.
- R3: When the main array holds the line, `rsp_valid` rises exactly one cycle after the request is accepted, with `rsp_hit`=1 and `rsp_vhit`=0, and no memory request is made.
- R4: When neither structure holds the line, `mem_req_valid` is raised with `mem_req_laddr` = `addr[ADDR_W-1 : log2(LINE_BYTES)]`. Both stay stable until `mem_req_ready` is sampled high, and each miss makes exactly one request.
- R5: One cycle after `mem_rsp_valid` is sampled, `rsp_valid` is 1 with `rsp_hit`=0 and `rsp_vhit`=0. The word comes from the returned line, and that line now occupies the main array.
- R6: A valid main line that a refill displaces enters the victim buffer. Slots are chosen round-robin, starting at slot 0 after reset, and the pointer advances only on such a push. The push therefore overwrites the oldest pushed entry.
- R7: When only the victim buffer holds the line, `rsp_valid` rises two cycles after acceptance, with `rsp_vhit`=1 and `rsp_hit`=0, and no memory request is made.
- R8: A victim hit moves the requested line into the main array, and the displaced main line takes the slot that was freed. The round-robin pointer does not move. A following access to the swapped-in line is a main hit, and one to the displaced line is a victim hit.
- R9: All victim slots are compared at the same time against the full line address (tag and index), so a slot can serve any index.
- R10: `req_ready` is 1 only while no request is in progress. From acceptance until the response, `req_ready` is 0, and `rsp_valid` is never 1 together with `req_ready`.
- R11: A refill into an index whose main line is invalid pushes nothing into the victim buffer and leaves the round-robin pointer where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | Response word valid for one cycle |
| rsp_data | output | WORD_W | Returned data word |
| rsp_hit | output | 1 | Response served by the main array |
| rsp_vhit | output | 1 | Response served through a victim swap |
| mem_req_valid | output | 1 | Line refill requested |
| mem_req_ready | input | 1 | Memory accepts the refill request |
| mem_req_laddr | output | ADDR_W-log2(LINE_BYTES) | Line address to refill |
| mem_rsp_valid | input | 1 | Refill line returned |
| mem_rsp_line | input | LINE_BYTES*8 | Returned line data |

## Verification
The bench builds the block with four main lines of 16 bytes and only two victim slots. With so few lines, index conflicts come up within a few accesses, and with two slots the round-robin pointer wraps often enough that a line evicted from the victim buffer can be checked as a fresh refill. Swaps between different indexes, pushes from an invalid main line and the hold of a stalled refill request are all reached this way. A behavioural model predicts the source, latency and data of every response.

// File: rtl/vc_pkg.sv
package vc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_MREQ,
      ST_MWAIT,
      ST_RESP
   } vc_state_e;

   typedef enum logic [1:0] {
      SRC_MAIN,
      SRC_VICT,
      SRC_MEM
   } vc_src_e;

   function automatic bit vc_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
   parameter int NUM_LINES = 64,
   parameter int TAG_W     = 22,
   parameter int LINE_W    = 256,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_line
);

   logic [NUM_LINES-1:0] vld_q;
   logic [TAG_W-1:0]     tag_q  [NUM_LINES];
   logic [LINE_W-1:0]    line_q [NUM_LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         line_q[wr_idx] <= wr_line;
      end
   end

   assign rd_valid = vld_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_line  = line_q[rd_idx];

endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
   parameter int DEPTH    = 4,
   parameter int LA_W     = 27,
   parameter int LINE_W   = 256,
   localparam int SLOT_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LA_W-1:0]   look_laddr,
   output logic              hit,
   output logic [SLOT_W-1:0] hit_slot,
   output logic [LINE_W-1:0] hit_line,
   input  logic              swap_en,
   input  logic              swap_valid,
   input  logic              push_en,
   input  logic [LA_W-1:0]   wr_laddr,
   input  logic [LINE_W-1:0] wr_line
);

   logic [DEPTH-1:0]  vld_q;
   logic [LA_W-1:0]   la_q   [DEPTH];
   logic [LINE_W-1:0] line_q [DEPTH];
   logic [DEPTH-1:0]  match;
   logic [SLOT_W-1:0] ptr;

   // one comparator per slot, all evaluated together
   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign match[i] = vld_q[i] && (la_q[i] == look_laddr);
   end

   always_comb begin
      hit_slot = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) hit_slot = SLOT_W'(i);
      end
   end

   assign hit      = |match;
   assign hit_line = line_q[hit_slot];

   // round-robin fill pointer, absent when there is a single slot
   if (DEPTH > 1) begin : g_ptr
      logic [SLOT_W-1:0] ptr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q <= '0;
         end else if (push_en) begin
            ptr_q <= (ptr_q == SLOT_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
         end
      end
      assign ptr = ptr_q;
   end else begin : g_no_ptr
      assign ptr = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (swap_en && hit_slot == SLOT_W'(i)) begin
               vld_q[i] <= swap_valid;
            end else if (push_en && ptr == SLOT_W'(i)) begin
               vld_q[i] <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if ((swap_en && hit_slot == SLOT_W'(i)) ||
             (push_en && ptr == SLOT_W'(i))) begin
            la_q[i]   <= wr_laddr;
            line_q[i] <= wr_line;
         end
      end
   end

endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
   import vc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [ADDR_W-1:0] q_addr,
   input  logic              main_valid,
   input  logic [TAG_W-1:0]  main_tag,
   input  logic              vic_hit,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   output logic              mem_req_valid,
   output logic              main_wr_en,
   output logic              main_wr_from_mem,
   output logic              vic_swap_en,
   output logic              vic_push_en,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_vhit
);

   vc_state_e state_q, state_d;
   vc_src_e   src_q, src_d;
   logic      tag_hit;

   assign tag_hit = main_valid && (main_tag == q_addr[ADDR_W-1 -: TAG_W]);

   always_comb begin
      state_d          = state_q;
      src_d            = src_q;
      req_ready        = 1'b0;
      mem_req_valid    = 1'b0;
      main_wr_en       = 1'b0;
      main_wr_from_mem = 1'b0;
      vic_swap_en      = 1'b0;
      vic_push_en      = 1'b0;
      rsp_valid        = 1'b0;
      rsp_hit          = 1'b0;
      rsp_vhit         = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            req_ready = 1'b1;
            if (req_valid) state_d = ST_LOOK;
         end
         ST_LOOK: begin
            if (tag_hit) begin
               rsp_valid = 1'b1;
               rsp_hit   = 1'b1;
               state_d   = ST_IDLE;
            end else if (vic_hit) begin
               main_wr_en  = 1'b1;
               vic_swap_en = 1'b1;
               src_d       = SRC_VICT;
               state_d     = ST_RESP;
            end else begin
               state_d = ST_MREQ;
            end
         end
         ST_MREQ: begin
            mem_req_valid = 1'b1;
            if (mem_req_ready) state_d = ST_MWAIT;
         end
         ST_MWAIT: begin
            if (mem_rsp_valid) begin
               main_wr_en       = 1'b1;
               main_wr_from_mem = 1'b1;
               vic_push_en      = main_valid;
               src_d            = SRC_MEM;
               state_d          = ST_RESP;
            end
         end
         ST_RESP: begin
            rsp_valid = 1'b1;
            rsp_vhit  = (src_q == SRC_VICT);
            state_d   = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         src_q   <= SRC_MAIN;
         q_addr  <= '0;
      end else begin
         state_q <= state_d;
         src_q   <= src_d;
         if (state_q == ST_IDLE && req_valid) q_addr <= req_addr;
      end
   end

endmodule

// File: rtl/vc_cache.sv
module vc_cache
   import vc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int NUM_LINES  = 64,
   parameter int VICT_DEPTH = 4,
   parameter int WORD_W     = 32,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int IDX_W     = $clog2(NUM_LINES),
   localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
   localparam int LA_W      = ADDR_W - OFF_W,
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int WB_W      = $clog2(WORD_W / 8),
   localparam int WPL       = LINE_W / WORD_W,
   localparam int SLOT_W    = (VICT_DEPTH > 1) ? $clog2(VICT_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_data,
   output logic              rsp_hit,
   output logic              rsp_vhit,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [LA_W-1:0]   mem_req_laddr,
   input  logic              mem_rsp_valid,
   input  logic [LINE_W-1:0] mem_rsp_line
);

   // parameter legality, checked at elaboration
   if (!vc_is_pow2(LINE_BYTES)) begin : g_bad_line
      $error("vc_cache: LINE_BYTES must be a power of two");
   end
   if (!vc_is_pow2(NUM_LINES) || NUM_LINES < 2) begin : g_bad_lines
      $error("vc_cache: NUM_LINES must be a power of two of at least 2");
   end
   if (WORD_W < 8 || !vc_is_pow2(WORD_W / 8) || (WORD_W % 8) != 0) begin : g_bad_word
      $error("vc_cache: WORD_W must be a power-of-two number of bytes");
   end
   if (WORD_W > LINE_W) begin : g_bad_ratio
      $error("vc_cache: a line must hold at least one word");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("vc_cache: ADDR_W leaves no tag bits");
   end
   if (VICT_DEPTH < 1) begin : g_bad_vict
      $error("vc_cache: VICT_DEPTH must be at least 1");
   end

   logic [ADDR_W-1:0] q_addr;
   logic [IDX_W-1:0]  q_idx;
   logic [TAG_W-1:0]  q_tag;
   logic [LA_W-1:0]   q_laddr;

   logic              main_valid;
   logic [TAG_W-1:0]  main_tag;
   logic [LINE_W-1:0] main_line;
   logic              main_wr_en;
   logic              main_wr_from_mem;
   logic [LINE_W-1:0] main_wr_line;

   logic              vic_hit;
   logic [SLOT_W-1:0] vic_slot;
   logic [LINE_W-1:0] vic_line;
   logic              vic_swap_en;
   logic              vic_push_en;

   assign q_idx         = q_addr[OFF_W +: IDX_W];
   assign q_tag         = q_addr[ADDR_W-1 -: TAG_W];
   assign q_laddr       = q_addr[ADDR_W-1:OFF_W];
   assign mem_req_laddr = q_laddr;
   assign main_wr_line  = main_wr_from_mem ? mem_rsp_line : vic_line;

   vc_ctrl #(
      .ADDR_W (ADDR_W),
      .TAG_W  (TAG_W)
   ) u_ctrl (
      .clk              (clk),
      .rst_n            (rst_n),
      .req_valid        (req_valid),
      .req_ready        (req_ready),
      .req_addr         (req_addr),
      .q_addr           (q_addr),
      .main_valid       (main_valid),
      .main_tag         (main_tag),
      .vic_hit          (vic_hit),
      .mem_req_ready    (mem_req_ready),
      .mem_rsp_valid    (mem_rsp_valid),
      .mem_req_valid    (mem_req_valid),
      .main_wr_en       (main_wr_en),
      .main_wr_from_mem (main_wr_from_mem),
      .vic_swap_en      (vic_swap_en),
      .vic_push_en      (vic_push_en),
      .rsp_valid        (rsp_valid),
      .rsp_hit          (rsp_hit),
      .rsp_vhit         (rsp_vhit)
   );

   vc_main_array #(
      .NUM_LINES (NUM_LINES),
      .TAG_W     (TAG_W),
      .LINE_W    (LINE_W)
   ) u_main (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (q_idx),
      .rd_valid (main_valid),
      .rd_tag   (main_tag),
      .rd_line  (main_line),
      .wr_en    (main_wr_en),
      .wr_idx   (q_idx),
      .wr_tag   (q_tag),
      .wr_line  (main_wr_line)
   );

   // displaced main line travels to the victim buffer on swap or push
   vc_victim_buf #(
      .DEPTH  (VICT_DEPTH),
      .LA_W   (LA_W),
      .LINE_W (LINE_W)
   ) u_vict (
      .clk        (clk),
      .rst_n      (rst_n),
      .look_laddr (q_laddr),
      .hit        (vic_hit),
      .hit_slot   (vic_slot),
      .hit_line   (vic_line),
      .swap_en    (vic_swap_en),
      .swap_valid (main_valid),
      .push_en    (vic_push_en),
      .wr_laddr   ({main_tag, q_idx}),
      .wr_line    (main_line)
   );

   logic unused_slot;
   assign unused_slot = ^vic_slot;

   // word selection: the response always reads the main array line
   if (WPL > 1) begin : g_wsel
      localparam int WS_W = $clog2(WPL);
      logic [WS_W-1:0] wsel;
      assign wsel     = q_addr[OFF_W-1:WB_W];
      assign rsp_data = main_line[wsel*WORD_W +: WORD_W];
   end else begin : g_wfull
      assign rsp_data = main_line[WORD_W-1:0];
   end

   if (WB_W > 0) begin : g_lsb
      logic unused_lsb;
      assign unused_lsb = ^q_addr[WB_W-1:0];
   end

endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   localparam int LA_W      = ADDR_W - $clog2(LINE_BYTES)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            rsp_valid,
   input logic            rsp_hit,
   input logic            rsp_vhit,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [LA_W-1:0] mem_req_laddr,
   input logic            mem_rsp_valid
);

   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!rsp_valid && !mem_req_valid && req_ready);
      end
   end

   // R3
   main_hit_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!rsp_valid || (rsp_hit && !rsp_vhit)));

   // R3
   lookup_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !mem_req_valid);

   // R4
   mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_laddr)));

   // R4
   mem_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

   // R5
   refill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |=> (rsp_valid && !rsp_hit && !rsp_vhit));

   // R7
   src_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit || rsp_vhit) |-> (rsp_valid && !(rsp_hit && rsp_vhit)));

   // R7
   vhit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vhit |-> !mem_req_valid);

   // R10
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R10
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

bind vc_cache vc_cache_chk #(
   .ADDR_W     (ADDR_W),
   .LINE_BYTES (LINE_BYTES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_hit       (rsp_hit),
   .rsp_vhit      (rsp_vhit),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_laddr (mem_req_laddr),
   .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/tb_vc_cache.sv
module tb_vc_cache;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 32;
   localparam int LB   = 16;
   localparam int NL   = 4;
   localparam int VN   = 2;
   localparam int WW   = 32;
   localparam int OFF  = $clog2(LB);
   localparam int LW   = LB * 8;
   localparam int WPL  = LW / WW;
   localparam int LAW  = AW - OFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid;
   logic [WW-1:0] rsp_data;
   logic          rsp_hit;
   logic          rsp_vhit;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b0;
   logic [LAW-1:0] mem_req_laddr;
   logic          mem_rsp_valid = 1'b0;
   logic [LW-1:0] mem_rsp_line = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural reference state
   bit mv [NL];
   int mt [NL];
   bit vv [VN];
   int vl [VN];
   int vp;

   vc_cache #(
      .ADDR_W     (AW),
      .LINE_BYTES (LB),
      .NUM_LINES  (NL),
      .VICT_DEPTH (VN),
      .WORD_W     (WW)
   ) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_addr      (req_addr),
      .rsp_valid     (rsp_valid),
      .rsp_data      (rsp_data),
      .rsp_hit       (rsp_hit),
      .rsp_vhit      (rsp_vhit),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_laddr (mem_req_laddr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_line  (mem_rsp_line)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(string r, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] word_of(int la, int w);
      return WW'(la * WPL + w) ^ WW'(32'h5A00_0000);
   endfunction

   function automatic logic [LW-1:0] line_of(int la);
      logic [LW-1:0] l;
      for (int w = 0; w < WPL; w++) l[w*WW +: WW] = word_of(la, w);
      return l;
   endfunction

   // one read, predicted by the model and checked cycle by cycle
   task automatic access(int a, string r);
      int la      = a >> OFF;
      int idx     = la % NL;
      int tg      = la / NL;
      int w       = (a / (WW / 8)) % WPL;
      int kind    = 2;
      int slot    = -1;
      int exp_lat = -1;
      int memcyc  = -1;
      bit got     = 0;
      if (mv[idx] && mt[idx] == tg) begin
         kind = 0;
      end else begin
         for (int s = 0; s < VN; s++) begin
            if (vv[s] && vl[s] == la) begin
               kind = 1;
               slot = s;
            end
         end
      end
      if (kind == 0) exp_lat = 1;
      if (kind == 1) exp_lat = 2;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = AW'(a);
      for (int c = 1; c <= 40 && !got; c++) begin
         @(negedge clk);
         req_valid     = 1'b0;
         mem_rsp_valid = 1'b0;
         if (memcyc >= 0 && c == memcyc + 2) begin
            mem_req_ready = 1'b0;
            chk("R4", "one request per miss", mem_req_valid, 0);
         end
         if (memcyc >= 0 && c == memcyc + 1) begin
            chk("R4", "request held while stalled", mem_req_valid, 1);
            chk("R4", "line address held", mem_req_laddr, la);
            mem_req_ready = 1'b1;
         end
         if (memcyc < 0 && mem_req_valid) begin
            memcyc = c;
            chk(r, "memory refill expected", kind, 2);
            chk("R4", "refill line address", mem_req_laddr, la);
         end
         if (memcyc >= 0 && c == memcyc + 4) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_line  = line_of(la);
            exp_lat       = memcyc + 5;
         end
         if (rsp_valid) begin
            got = 1;
            chk(r, "response latency", c, exp_lat);
            chk(r, "rsp_hit flag", rsp_hit, kind == 0);
            chk(r, "rsp_vhit flag", rsp_vhit, kind == 1);
            chk("R2", "returned word", rsp_data, word_of(la, w));
            chk("R10", "ready low with response", req_ready, 0);
         end else begin
            chk("R10", "ready low while busy", req_ready, 0);
         end
      end
      if (!got) chk(r, "response seen", 0, 1);
      if (kind == 1) begin
         vv[slot] = mv[idx];
         vl[slot] = mt[idx] * NL + idx;
         mv[idx]  = 1;
         mt[idx]  = tg;
      end else if (kind == 2) begin
         if (mv[idx]) begin
            vv[vp] = 1;
            vl[vp] = mt[idx] * NL + idx;
            vp     = (vp + 1) % VN;
         end
         mv[idx] = 1;
         mt[idx] = tg;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int seed;
      for (int i = 0; i < NL; i++) begin mv[i] = 0; mt[i] = 0; end
      for (int i = 0; i < VN; i++) begin vv[i] = 0; vl[i] = 0; end
      vp = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle state after reset
      chk("R1", "req_ready after reset", req_ready, 1);
      chk("R1", "rsp_valid after reset", rsp_valid, 0);
      chk("R1", "mem_req_valid after reset", mem_req_valid, 0);

      access(32'h008, "R1");   // cold miss
      access(32'h008, "R3");   // main hit
      access(32'h004, "R2");   // other word, same line
      access(32'h040, "R5");   // conflict miss, old line pushed to slot 0
      access(32'h04C, "R3");
      access(32'h000, "R7");   // victim hit and swap
      access(32'h00C, "R8");   // swapped-in line now in main
      access(32'h040, "R8");   // displaced line now in victim
      access(32'h010, "R11");  // fill into invalid index, no push
      access(32'h000, "R11");  // earlier victim entry still present
      access(32'h080, "R6");
      access(32'h0C0, "R6");
      access(32'h040, "R6");   // evicted by round-robin, refilled
      access(32'h080, "R9");
      access(32'h050, "R9");
      access(32'h014, "R9");   // match on a line of index 1

      seed = 7;
      for (int n = 0; n < 80; n++) begin
         seed = (seed * 1103515245 + 12345) & 32'h7FFF_FFFF;
         access(((seed >> 8) % 6) * 64 + ((seed >> 4) % NL) * LB + (seed % WPL) * 4, "R9");
      end

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule